// File: doc/BRIEF.md
# Burst SPI Master with Write, Read and Exchange Modes

This block is a byte-oriented SPI master that runs a burst of one or more bytes inside a single chip-select window. The host pulses `start` and gives a byte count, a transfer kind, the clock polarity and phase, a clock divider and a filler byte. The block then lowers `cs_n`, clocks eight SCK cycles per byte with the most significant bit first, and raises `cs_n` again. Transmit bytes are pulled from the host through a one-cycle `tx_ready` handshake. Received bytes are handed back through a one-cycle `rx_valid` strobe.

There are three transfer kinds. A write-only burst sends host bytes and drops whatever arrives on MISO. A read-only burst sends the filler byte for every position, asks the host for no data, and returns each MISO byte. An exchange burst pairs every sent byte with the byte received at the same time. The SCK half period is a whole number of system clocks, so the achieved rate never exceeds the one requested. The divider latched for the current or last burst is echoed on `div_rb`.

The controller is a five-state machine:
- IDLE waits. An accepted start moves it to LEAD.
- LEAD holds CS low for one half period. Its tick moves it to SHIFT.
- SHIFT makes one SCK edge per tick. The last edge of the last byte moves it to TRAIL.
- TRAIL holds CS low for one more half period. Its tick moves it to DONE.
- DONE lasts one cycle with CS high and always returns to IDLE.

Top module: `spi_burst_master`

## Requirements
- R1: `cs_n` is high while idle. It is low from the cycle after an accepted start until the burst ends, for exactly (half_div+1)·(16·N+2) system clocks for N bytes. This leaves one half period with no SCK edge before the first edge and one after the last edge.
- R2: A start is accepted only in IDLE with a nonzero `byte_count`. A start during a burst, or with a zero count, is ignored: no new CS window opens and the latched configuration (`div_rb`, transfer kind) is unchanged.
- R3: Transfer kind 2'b00 (write-only) shifts the host bytes out on MOSI, MSB first, and produces no `rx_valid` strobe.
- R4: Transfer kind 2'b01 (read-only) sends `fill_byte` on MOSI for every byte, never raises `tx_ready`, and gives one `rx_valid` per byte carrying the MISO byte, MSB first.
- R5: Transfer kinds 2'b10 and 2'b11 (exchange) raise `tx_ready` N times and `rx_valid` N times. The k-th received byte is the one sampled while the k-th sent byte was on MOSI.
- R6: Each SCK half period lasts `half_div`+1 system clocks. `div_rb` shows the divider latched at the accepted start.
- R7: While idle, `sck` follows `cpol`. During a burst SCK starts and ends at the latched polarity.
- R8: With `cpha`=0, MOSI holds each bit before the leading SCK edge and MISO is sampled on the leading edge. With `cpha`=1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R9: `busy` is high from the cycle after an accepted start until `cs_n` rises. `done` is high for exactly one cycle: the first cycle with `cs_n` high again.
- R10: `tx_ready` is a one-cycle pulse. `tx_data` is captured at the clock edge that ends it. The first pulse comes in the cycle of the accepted start; each later one comes at the last SCK edge of the byte before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Burst request pulse |
| xfer_mode | input | 2 | Transfer kind: 00 write, 01 read, 10/11 exchange |
| byte_count | input | LEN_W | Number of bytes in the burst |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | Sampling edge select |
| half_div | input | DIV_W | SCK half period minus one, in system clocks |
| fill_byte | input | 8 | Byte sent in read-only bursts |
| tx_data | input | 8 | Next byte to send |
| tx_ready | output | 1 | Pulse: tx_data taken at this edge |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Pulse: rx_data holds a new byte |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| div_rb | output | DIV_W | Latched divider value |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data in |

## Verification
`cs_n` and `busy` change in the first cycle after the edge that samples `start`. `tx_ready` is combinational in the start cycle and at each last SCK edge of a byte. `rx_valid` rises one cycle after the final SCK edge of its byte. `done` shows up exactly (half_div+1)·(16·N+2) cycles after CS falls. The bench samples every output on the falling system clock, midway between active edges. A slave model in the bench detects SCK edges by comparing against the level it saw at the previous falling edge, and uses the MOSI value held from before that edge. The host model moves `tx_data` only at the falling edge after the clock edge that consumed it. Cycle-exact claims are checked as counts of CS-low cycles and as strobe counts per burst.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    localparam int WORD_BITS = 8;

    typedef enum logic [1:0] {
        XF_WRITE      = 2'b00,
        XF_READ       = 2'b01,
        XF_EXCHANGE   = 2'b10,
        XF_EXCHANGE_B = 2'b11
    } xfer_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_DONE
    } state_t;

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = !clear && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: the counter never runs past the latched limit
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (cnt_q <= limit));

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sample,
    input  logic         miso,
    output logic         mosi,
    output logic [W-1:0] rx_cur,
    output logic [W-1:0] rx_next
);

    logic [W-1:0] tx_sh_q;
    logic [W-1:0] rx_sh_q;

    assign mosi    = tx_sh_q[W-1];
    assign rx_cur  = rx_sh_q;
    assign rx_next = {rx_sh_q[W-2:0], miso};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh_q <= '0;
            rx_sh_q <= '0;
        end else begin
            if (load) begin
                tx_sh_q <= load_val;
            end else if (shift) begin
                tx_sh_q <= {tx_sh_q[W-2:0], 1'b0};
            end
            if (sample) begin
                rx_sh_q <= {rx_sh_q[W-2:0], miso};
            end
        end
    end

    // R8: loading and shifting never collide in one cycle
    p_load_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> !load);

endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
    import spi_burst_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       xfer_mode,
    input  logic [LEN_W-1:0] byte_count,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [DIV_W-1:0] half_div,
    input  logic [7:0]       fill_byte,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             busy,
    output logic             done,
    output logic [DIV_W-1:0] div_rb,
    output logic             sck,
    output logic             mosi,
    output logic             cs_n,
    input  logic             miso
);

    localparam int EDGE_W = $clog2(2 * WORD_BITS);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * WORD_BITS - 1);

    state_t             state_q, state_d;
    xfer_t              mode_q, mode_eff;
    logic               cpol_q, cpha_q, sck_q;
    logic [DIV_W-1:0]   div_q;
    logic [7:0]         fill_q, fill_eff;
    logic [LEN_W-1:0]   left_q;
    logic [EDGE_W-1:0]  edge_q;
    logic [7:0]         rx_data_q;
    logic               rx_valid_q;

    logic tick, clear, start_ok, edge_tick, byte_end;
    logic load, shift, sample;
    logic [7:0] load_val, rx_cur, rx_next;

    assign start_ok  = (state_q == ST_IDLE) && start && (byte_count != '0);
    assign clear     = (state_q == ST_IDLE) || (state_q == ST_DONE);
    assign edge_tick = (state_q == ST_SHIFT) && tick;
    assign byte_end  = edge_tick && (edge_q == LAST_EDGE);

    assign mode_eff = (state_q == ST_IDLE) ? xfer_t'(xfer_mode) : mode_q;
    assign fill_eff = (state_q == ST_IDLE) ? fill_byte : fill_q;
    assign load     = start_ok || (byte_end && (left_q != '0));
    assign load_val = (mode_eff == XF_READ) ? fill_eff : tx_data;
    assign sample   = edge_tick && (edge_q[0] == cpha_q);
    assign shift    = edge_tick && (edge_q[0] != cpha_q)
                      && (edge_q != '0) && (edge_q != LAST_EDGE);

    spi_tick_gen #(.DIV_W(DIV_W)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .limit (div_q),
        .tick  (tick)
    );

    spi_byte_shifter #(.W(WORD_BITS)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .shift    (shift),
        .sample   (sample),
        .miso     (miso),
        .mosi     (mosi),
        .rx_cur   (rx_cur),
        .rx_next  (rx_next)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_ok) state_d = ST_LEAD;
            ST_LEAD:  if (tick) state_d = ST_SHIFT;
            ST_SHIFT: if (byte_end && (left_q == '0)) state_d = ST_TRAIL;
            ST_TRAIL: if (tick) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath and configuration latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= XF_WRITE;
            cpol_q     <= 1'b0;
            cpha_q     <= 1'b0;
            div_q      <= '0;
            fill_q     <= '0;
            left_q     <= '0;
            edge_q     <= '0;
            sck_q      <= 1'b0;
            rx_data_q  <= '0;
            rx_valid_q <= 1'b0;
        end else begin
            rx_valid_q <= 1'b0;
            if (state_q == ST_IDLE) begin
                sck_q  <= cpol;
                edge_q <= '0;
                if (start_ok) begin
                    mode_q <= xfer_t'(xfer_mode);
                    cpol_q <= cpol;
                    cpha_q <= cpha;
                    div_q  <= half_div;
                    fill_q <= fill_byte;
                    left_q <= byte_count - 1'b1;
                end
            end
            if (edge_tick) begin
                sck_q  <= ~sck_q;
                edge_q <= edge_q + 1'b1;
            end
            if (byte_end) begin
                rx_data_q  <= cpha_q ? rx_next : rx_cur;
                rx_valid_q <= (mode_q != XF_WRITE);
                if (left_q != '0) left_q <= left_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q == ST_LEAD) || (state_q == ST_SHIFT) || (state_q == ST_TRAIL);
        cs_n     = !busy;
        done     = (state_q == ST_DONE);
        tx_ready = load && (mode_eff != XF_READ);
        sck      = sck_q;
        div_rb   = div_q;
        rx_data  = rx_data_q;
        rx_valid = rx_valid_q;
    end

    p_rx_silent_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (mode_q != XF_WRITE));

    p_no_tx_pull_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (mode_q == XF_READ)) |-> !tx_ready);

    p_sck_home_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAIL) |-> (sck == cpol_q));

    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && start) |=> ($stable(div_rb) && $stable(mode_q)));

    p_done_after_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(!cs_n)));

    p_edges_in_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_q) != ST_IDLE) && (sck != $past(sck))) |-> ($past(state_q) == ST_SHIFT));

endmodule

// File: tb/test_spi_burst_master.sv
module test_spi_burst_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  xfer_mode = 2'b00;
    logic [7:0]  byte_count = 8'd0;
    logic        cpol = 1'b0;
    logic        cpha = 1'b0;
    logic [7:0]  half_div = 8'd0;
    logic [7:0]  fill_byte = 8'h00;
    logic [7:0]  tx_data;
    logic        tx_ready;
    logic [7:0]  rx_data;
    logic        rx_valid, busy, done, sck, mosi, cs_n;
    logic [7:0]  div_rb;
    logic        miso = 1'b0;

    always #4 clk = ~clk;

    spi_burst_master i_spi_burst_master (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_mode(xfer_mode),
        .byte_count(byte_count), .cpol(cpol), .cpha(cpha), .half_div(half_div),
        .fill_byte(fill_byte), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy), .done(done),
        .div_rb(div_rb), .sck(sck), .mosi(mosi), .cs_n(cs_n), .miso(miso)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // bench-side host and slave state
    bit          cpol_cur = 0, cpha_cur = 0;
    int          ncur = 0;
    logic [23:0] rsp_cur = '0, tx_cur = '0, cap = '0, rxcap = '0;
    int          oidx = 0, tx_idx = 0, rxcnt = 0, txcnt = 0, cslow = 0;
    bit          tx_seen_q = 0, rise_pend = 0, got_done = 0;
    logic        done_rise = 0, busy_rise = 0, done_after = 0;
    logic        sck_d = 0, cs_d = 1, mosi_d = 0;

    always_comb tx_data = (tx_idx < 3) ? tx_cur[23 - 8*tx_idx -: 8] : 8'h00;

    function automatic logic rsp_bit(input int k);
        logic [7:0] b;
        if (k >= 8 * ncur) return 1'b0;
        b = rsp_cur[23 - 8*(k/8) -: 8];
        return b[7 - (k % 8)];
    endfunction

    always @(negedge clk) begin
        if (tx_seen_q) tx_idx++;
        tx_seen_q = tx_ready;
        if (tx_ready) txcnt++;
        if (rx_valid) begin
            rxcap = {rxcap[15:0], rx_data};
            rxcnt++;
        end
        if (!cs_n) cslow++;
        if (cs_d && !cs_n) begin
            oidx = 0;
            if (!cpha_cur) begin
                miso = rsp_bit(0);
                oidx = 1;
            end
        end else if (!cs_n && (sck != sck_d)) begin
            if ((sck_d == cpol_cur) == !cpha_cur) begin
                cap = {cap[22:0], mosi_d};
            end else begin
                miso = rsp_bit(oidx);
                oidx++;
            end
        end
        if (!cs_d && cs_n) begin
            done_rise = done;
            busy_rise = busy;
            rise_pend = 1;
        end else if (rise_pend) begin
            done_after = done;
            rise_pend = 0;
            got_done = 1;
        end
        sck_d  = sck;
        cs_d   = cs_n;
        mosi_d = mosi;
    end

    function automatic logic [23:0] pack(input int n, input logic [23:0] src,
                                         input bit use_fill, input logic [7:0] fb);
        logic [23:0] r = '0;
        for (int b = 0; b < n; b++) r = {r[15:0], use_fill ? fb : src[23 - 8*b -: 8]};
        return r;
    endfunction

    task automatic run_xfer(input logic [1:0] m, input bit pol, input bit pha,
                            input logic [7:0] dv, input int n, input logic [23:0] tx,
                            input logic [23:0] rsp, input logic [7:0] fb, input bit poke);
        @(posedge clk); #2;
        xfer_mode = m; cpol = pol; cpha = pha; half_div = dv;
        byte_count = 8'(n); fill_byte = fb;
        cpol_cur = pol; cpha_cur = pha; ncur = n; rsp_cur = rsp; tx_cur = tx;
        tx_idx = 0; tx_seen_q = 0; cap = '0; rxcap = '0; rxcnt = 0; txcnt = 0;
        cslow = 0; got_done = 0;
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        if (poke) begin
            repeat (10) @(posedge clk);
            #2 half_div = 8'd7; xfer_mode = 2'b00; start = 1'b1;
            @(posedge clk); #2 start = 1'b0;
        end
        while (!got_done) @(negedge clk);
        @(negedge clk);
        check("R1", "cs low cycles", cslow, (dv + 1) * (16 * n + 2));
        check(m == 2'b00 ? "R3" : (m == 2'b01 ? "R4" : "R5"), "mosi stream",
              cap, pack(n, tx, m == 2'b01, fb));
        check(m == 2'b00 ? "R3" : "R5", "rx strobes", rxcnt, (m == 2'b00) ? 0 : n);
        if (m != 2'b00) check("R8", "rx stream", rxcap, pack(n, rsp, 1'b0, 8'h00));
        check("R10", "tx_ready pulses", txcnt, (m == 2'b01) ? 0 : n);
        check("R9", "done at cs rise", done_rise, 1);
        check("R9", "busy low at cs rise", busy_rise, 0);
        check("R9", "done one cycle", done_after, 0);
        check("R7", "sck back at idle", sck, pol);
        check("R6", "divider readback", div_rb, dv);
    endtask

    // {kind, cpol, cpha, div[3:0], count, tx bytes, slave reply bytes}
    localparam logic [63:0] VECS [6] = '{
        {2'd0, 1'b0, 1'b0, 4'd1, 8'd3, 24'hA53C01, 24'h112233},
        {2'd1, 1'b0, 1'b0, 4'd0, 8'd2, 24'h000000, 24'h9FC400},
        {2'd2, 1'b0, 1'b1, 4'd2, 8'd3, 24'h8F007E, 24'h004281},
        {2'd2, 1'b1, 1'b0, 4'd1, 8'd1, 24'hC30000, 24'h5A0000},
        {2'd3, 1'b1, 1'b1, 4'd0, 8'd2, 24'h123400, 24'hFE0100},
        {2'd1, 1'b1, 1'b1, 4'd3, 8'd1, 24'h000000, 24'h800000}
    };

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog: actual no done expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset cs_n", cs_n, 1);
        check("R9", "reset busy", busy, 0);
        check("R9", "reset done", done, 0);
        check("R3", "reset rx_valid", rx_valid, 0);
        check("R7", "reset sck", sck, 0);
        check("R10", "reset tx_ready", tx_ready, 0);

        @(posedge clk); #2 cpol = 1'b1;
        repeat (2) @(negedge clk);
        check("R7", "idle sck follows cpol", sck, 1);
        @(posedge clk); #2 cpol = 1'b0;

        for (int i = 0; i < 6; i++) begin
            run_xfer(VECS[i][63:62], VECS[i][61], VECS[i][60], {4'd0, VECS[i][59:56]},
                     int'(VECS[i][55:48]), VECS[i][47:24], VECS[i][23:0], 8'h00, 1'b0);
        end

        // R2: zero count is ignored
        @(posedge clk); #2 byte_count = 8'd0; start = 1'b1; cslow = 0;
        @(posedge clk); #2 start = 1'b0;
        repeat (10) @(negedge clk);
        check("R2", "zero count cs low cycles", cslow, 0);
        check("R2", "zero count busy", busy, 0);

        // R2: start during a burst is ignored
        run_xfer(2'd2, 1'b0, 1'b0, 8'd2, 1, 24'h3C0000, 24'hA50000, 8'h00, 1'b1);
        cslow = 0;
        repeat (20) @(negedge clk);
        check("R2", "no second burst", cslow, 0);

        // R4: nonzero filler byte
        run_xfer(2'd1, 1'b0, 1'b0, 8'd1, 2, 24'h000000, 24'h0FF000, 8'h5A, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule